// File: doc/BRIEF.md
# DMA Bus Master Cycle Controller

This block turns transfer requests from an on-chip DMA engine into cycles on a host bus. The bus carries 24-bit addresses and 16-bit data. The low 16 address bits share the data lines, and the top 8 address bits have their own outputs. A requester presents an address, write data, a byte-or-word flag and a direction. The block first wins ownership of the bus through a request/grant pair. It then runs an address phase and a data phase with the proper strobes and transceiver enables. For a read, it hands the sampled data back to the requester.

Each bus cycle lasts at least six clocks. The cycle then waits one clock at a time until the addressed memory signals ready. Three settings shape the bus behaviour:
- A style bit selects the arbitration rule and the byte-lane encoding. The alternate style also adds a grant pass-through output for daisy-chained masters.
- A polarity bit flips the address strobe between an active-high latch enable and an active-low strobe.
- A burst setting limits how many transfers run in one ownership period. The host may also cut a burst short through a release input, when that input is enabled.

Top module: `dmab_top`

## Requirements
- R1: A transfer occupies the bus for exactly 6 + k clocks, where k is the number of extra clocks that ready stays low after the data phase would otherwise end. The result (`rsp_valid`, and `rsp_rdata` for reads) appears the clock after the last bus clock.
- R2: In style 0, `bm_o` encodes the lanes as 00 for a whole word, 01 for the upper byte (bits 15:8, odd address) and 10 for the lower byte (bits 7:0, even address).
- R3: In style 1, `bm_o[0]` is a byte flag (1 = byte) and `bm_o[1]` is 0. Address bit 0 on `dal_out_o` chooses the lane (0 = lower, 1 = upper). For a word transfer, bit 0 is forced to 0.
- R4: With `cfg_as_low`=0, `as_o` is 1 during the first two clocks of a cycle and 0 afterwards. With `cfg_as_low`=1, the levels are inverted.
- R5: While the block is master, `rd_o` is 1 for a read and 0 for a write.
- R6: `dalo_o` is 1 in the address phase and, for writes, in the data phase as well. `dali_o` is 1 only in the data phase of a read.
- R7: In the address phase, `dal_out_o` carries address bits 15:0, and `addr_hi_o` carries bits 23:16. In the data phase of a write, `dal_out_o` carries the write data. For a read, `rsp_rdata` returns `dal_in_i`.
- R8: With style 0, `bus_req_o` rises the clock after the grant is seen low. With style 1, the grant must also have been low on the clock before, which costs one more clock.
- R9: `bus_req_o` stays high for the whole ownership period and falls on the same edge on which the last cycle ends.
- R10: `chain_gnt_o` is 1 only in style 1, when the grant is high and the block is not requesting.
- R11: `cfg_burst` 00 allows 1 transfer per ownership period, 01 allows 8, and 1x allows an unlimited number.
- R12: If `cfg_rel_en`=1 and `bus_rel_i` is high during a transfer, the ownership period ends after that transfer. If `cfg_rel_en`=0, the release input has no effect.
- R13: When the block is not master, `bus_drive_o` is 0 and every bus output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_alt_mode | input | 1 | Style: 0 = mask lanes and plain request, 1 = byte flag, edge request and grant chain |
| cfg_as_low | input | 1 | Address strobe polarity: 1 = active low |
| cfg_burst | input | 2 | Burst limit: 00 = 1, 01 = 8, 1x = unlimited |
| cfg_rel_en | input | 1 | Enables the host release input |
| req_valid | input | 1 | A transfer request is pending |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer |
| req_ack | output | 1 | The request is taken at the coming edge |
| rsp_valid | output | 1 | One-clock pulse when a transfer completes |
| rsp_rdata | output | 16 | Read data of the last read |
| bus_req_o | output | 1 | Bus request |
| bus_grant_i | input | 1 | Bus grant |
| bus_rel_i | input | 1 | Host request to end the burst |
| bus_ready_i | input | 1 | Memory ready |
| chain_gnt_o | output | 1 | Grant passed to the next master |
| bus_drive_o | output | 1 | Output enable for all bus drivers |
| addr_hi_o | output | 8 | Address bits 23:16 |
| dal_out_o | output | 16 | Multiplexed address/data out |
| dal_in_i | input | 16 | Multiplexed data in |
| as_o | output | 1 | Address latch enable or address strobe |
| das_o | output | 1 | Data strobe (active high) |
| rd_o | output | 1 | Direction: 1 = read |
| dalo_o | output | 1 | Outbound transceiver enable |
| dali_o | output | 1 | Inbound transceiver enable |
| bm_o | output | 2 | Byte lane select |

## Verification
The bench targets four weak points:
- **Cycle length.** Ready is delayed by zero to five clocks, and the bench counts bus clocks. A controller that samples ready one phase early or late shows a cycle one clock off.
- **Word at an odd address in the alternate style.** A design that passes address bit 0 through on a word transfer would produce the illegal lane combination.
- **Request rule difference.** HOLD and BUSRQ styles are compared on the exact clock the request rises after the grant falls. Swapped rules show up as a one-clock difference.
- **Burst boundaries.** Bursts of 1, 8 and unlimited, with and without release, are checked by counting ownership periods. An off-by-one counter, or a release that is not latched across the transfer, changes that count.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    localparam int BUS_AW = 24;
    localparam int BUS_DW = 16;
    localparam int HI_W   = BUS_AW - BUS_DW;

    typedef enum logic {SQ_IDLE, SQ_BUS} seq_state_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
        logic              write;
        logic              byte_sel;
    } xfer_t;

    // lane code for the mask style: 00 word, 01 upper byte, 10 lower byte
    function automatic logic [1:0] mask_code(input logic is_byte, input logic a0);
        if (!is_byte)
            return 2'b00;
        return a0 ? 2'b01 : 2'b10;
    endfunction
endpackage

// File: rtl/dmab_arbiter.sv
module dmab_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic cfg_alt,
    input  logic want,
    input  logic grant,
    input  logic master,
    input  logic release_i,
    output logic bus_req,
    output logic chain_gnt
);
    logic grant_q;
    logic may_raise;

    // style 1 needs the grant low on two consecutive samples
    assign may_raise = want && !grant && (!cfg_alt || !grant_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req <= 1'b0;
            grant_q <= 1'b0;
        end else begin
            grant_q <= grant;
            if (bus_req) begin
                if (release_i || (!want && !master))
                    bus_req <= 1'b0;
            end else if (may_raise) begin
                bus_req <= 1'b1;
            end
        end
    end

    assign chain_gnt = cfg_alt && grant && !bus_req;

    // R8
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(!grant));
endmodule

// File: rtl/dmab_lane_enc.sv
module dmab_lane_enc (
    input  logic       cfg_alt,
    input  logic       is_byte,
    input  logic       a0,
    output logic [1:0] bm,
    output logic       a0_out
);
    always_comb begin
        if (cfg_alt) begin
            bm     = {1'b0, is_byte};
            a0_out = is_byte && a0;
        end else begin
            bm     = dmab_pkg::mask_code(is_byte, a0);
            a0_out = a0;
        end
    end
endmodule

// File: rtl/dmab_sequencer.sv
module dmab_sequencer #(
    parameter int MIN_PH  = 6,
    parameter int ADDR_PH = 2,
    parameter int STB_PH  = 3,
    parameter int MID     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_req,
    input  logic                          grant,
    input  logic                          ready,
    input  logic                          req_valid,
    input  dmab_pkg::xfer_t               req_x,
    input  logic [1:0]                    cfg_burst,
    input  logic                          cfg_rel_en,
    input  logic                          rel_in,
    input  logic [dmab_pkg::BUS_DW-1:0]   dal_in,
    output logic                          master,
    output logic                          ph_addr,
    output logic                          ph_strobe,
    output dmab_pkg::xfer_t               cur,
    output logic                          req_ack,
    output logic                          release_o,
    output logic                          rsp_valid,
    output logic [dmab_pkg::BUS_DW-1:0]   rsp_rdata
);
    import dmab_pkg::*;

    localparam int PH_W    = $clog2(MIN_PH);
    localparam int BC_W    = $clog2(MID);
    localparam int PH_LAST = MIN_PH - 1;

    seq_state_e        state;
    logic [PH_W-1:0]   ph;
    logic [BC_W-1:0]   cnt;
    logic              rel_seen;
    logic              done, start, cont, limit_hit, rel_now;

    assign master    = (state == SQ_BUS);
    assign ph_addr   = master && (ph < PH_W'(ADDR_PH));
    assign ph_strobe = master && (ph >= PH_W'(STB_PH));
    assign done      = master && (ph == PH_W'(PH_LAST)) && ready;
    assign start     = (state == SQ_IDLE) && bus_req && grant && req_valid;
    assign rel_now   = rel_seen || (cfg_rel_en && rel_in);

    always_comb begin
        unique case (cfg_burst)
            2'b00:   limit_hit = 1'b1;
            2'b01:   limit_hit = (cnt == BC_W'(MID - 1));
            default: limit_hit = 1'b0;
        endcase
    end

    assign cont      = req_valid && !limit_hit && !rel_now;
    assign req_ack   = start || (done && cont);
    assign release_o = done && !cont;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            ph        <= '0;
            cnt       <= '0;
            rel_seen  <= 1'b0;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (done && !cur.write)
                rsp_rdata <= dal_in;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state    <= SQ_BUS;
                        ph       <= '0;
                        cnt      <= '0;
                        rel_seen <= 1'b0;
                        cur      <= req_x;
                    end
                end
                SQ_BUS: begin
                    if (cfg_rel_en && rel_in)
                        rel_seen <= 1'b1;
                    if (ph != PH_W'(PH_LAST)) begin
                        ph <= ph + 1'b1;
                    end else if (ready) begin
                        ph       <= '0;
                        rel_seen <= 1'b0;
                        if (cont) begin
                            cur <= req_x;
                            cnt <= cnt + 1'b1;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R1
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(ph_strobe) && $past(ph_strobe, 3)));
    // R11
    single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && cfg_burst == 2'b00 && $stable(cfg_burst)) |-> !master);
endmodule

// File: rtl/dmab_top.sv
module dmab_top #(
    parameter int MIN_PH  = 6,
    parameter int ADDR_PH = 2,
    parameter int STB_PH  = 3,
    parameter int MID     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_alt_mode,
    input  logic                         cfg_as_low,
    input  logic [1:0]                   cfg_burst,
    input  logic                         cfg_rel_en,
    input  logic                         req_valid,
    input  logic [dmab_pkg::BUS_AW-1:0]  req_addr,
    input  logic [dmab_pkg::BUS_DW-1:0]  req_wdata,
    input  logic                         req_write,
    input  logic                         req_byte,
    output logic                         req_ack,
    output logic                         rsp_valid,
    output logic [dmab_pkg::BUS_DW-1:0]  rsp_rdata,
    output logic                         bus_req_o,
    input  logic                         bus_grant_i,
    input  logic                         bus_rel_i,
    input  logic                         bus_ready_i,
    output logic                         chain_gnt_o,
    output logic                         bus_drive_o,
    output logic [dmab_pkg::HI_W-1:0]    addr_hi_o,
    output logic [dmab_pkg::BUS_DW-1:0]  dal_out_o,
    input  logic [dmab_pkg::BUS_DW-1:0]  dal_in_i,
    output logic                         as_o,
    output logic                         das_o,
    output logic                         rd_o,
    output logic                         dalo_o,
    output logic                         dali_o,
    output logic [1:0]                   bm_o
);
    import dmab_pkg::*;

    xfer_t      req_x, cur;
    logic       master, ph_addr, ph_strobe, release_w;
    logic [1:0] bm_w;
    logic       a0_w;

    assign req_x = '{addr: req_addr, wdata: req_wdata, write: req_write, byte_sel: req_byte};

    dmab_arbiter u_arb (
        .clk(clk), .rst(rst), .cfg_alt(cfg_alt_mode), .want(req_valid),
        .grant(bus_grant_i), .master(master), .release_i(release_w),
        .bus_req(bus_req_o), .chain_gnt(chain_gnt_o)
    );

    dmab_sequencer #(.MIN_PH(MIN_PH), .ADDR_PH(ADDR_PH), .STB_PH(STB_PH), .MID(MID)) u_seq (
        .clk(clk), .rst(rst), .bus_req(bus_req_o), .grant(bus_grant_i),
        .ready(bus_ready_i), .req_valid(req_valid), .req_x(req_x),
        .cfg_burst(cfg_burst), .cfg_rel_en(cfg_rel_en), .rel_in(bus_rel_i),
        .dal_in(dal_in_i), .master(master), .ph_addr(ph_addr),
        .ph_strobe(ph_strobe), .cur(cur), .req_ack(req_ack),
        .release_o(release_w), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    dmab_lane_enc u_lane (
        .cfg_alt(cfg_alt_mode), .is_byte(cur.byte_sel), .a0(cur.addr[0]),
        .bm(bm_w), .a0_out(a0_w)
    );

    always_comb begin
        bus_drive_o = master;
        addr_hi_o   = '0;
        dal_out_o   = '0;
        as_o        = 1'b0;
        das_o       = 1'b0;
        rd_o        = 1'b0;
        dalo_o      = 1'b0;
        dali_o      = 1'b0;
        bm_o        = 2'b00;
        if (master) begin
            addr_hi_o = cur.addr[BUS_AW-1:BUS_DW];
            if (ph_addr)
                dal_out_o = {cur.addr[BUS_DW-1:1], a0_w};
            else if (cur.write)
                dal_out_o = cur.wdata;
            as_o   = ph_addr ^ cfg_as_low;
            das_o  = ph_strobe;
            rd_o   = !cur.write;
            dalo_o = ph_addr || cur.write;
            dali_o = !ph_addr && !cur.write;
            bm_o   = bm_w;
        end
    end

    // R9
    own_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_drive_o |-> bus_req_o);
    // R6
    dali_dir_chk: assert property (@(posedge clk) disable iff (rst)
        dali_o |-> (rd_o && !dalo_o));
    // R10
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        chain_gnt_o |-> !bus_drive_o);
endmodule

// File: tb/dmab_top_tb_top.sv
`timescale 1ns/1ps
module dmab_top_tb_top;
    typedef struct packed {
        logic        alt;
        logic        asl;
        logic        wr;
        logic        byt;
        logic [23:0] addr;
        logic [15:0] wd;
        logic [15:0] rdv;
        logic [3:0]  k;
        logic [1:0]  ebm;
        logic [15:0] edal;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 24'h123456, 16'h0000, 16'hA5C3, 4'd0, 2'b00, 16'h3456},
        '{1'b0, 1'b1, 1'b1, 1'b1, 24'hAB0101, 16'h77EE, 16'h0000, 4'd2, 2'b01, 16'h0101},
        '{1'b0, 1'b0, 1'b1, 1'b1, 24'h000FF0, 16'h1357, 16'h0000, 4'd1, 2'b10, 16'h0FF0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 24'h7F8001, 16'h0000, 16'h1234, 4'd3, 2'b01, 16'h8001},
        '{1'b1, 1'b1, 1'b1, 1'b0, 24'h012345, 16'hC0DE, 16'h0000, 4'd0, 2'b00, 16'h2344},
        '{1'b1, 1'b0, 1'b0, 1'b1, 24'hFFFFFE, 16'h0000, 16'hBEEF, 4'd5, 2'b01, 16'hFFFE},
        '{1'b0, 1'b1, 1'b0, 1'b1, 24'h800002, 16'h0000, 16'h00FF, 4'd1, 2'b10, 16'h0002},
        '{1'b1, 1'b1, 1'b1, 1'b1, 24'h55AAAB, 16'h0F0F, 16'h0000, 4'd0, 2'b01, 16'hAAAB}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_alt_mode = 1'b0, cfg_as_low = 1'b0, cfg_rel_en = 1'b0;
    logic [1:0] cfg_burst = 2'b00;
    logic req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0, dal_in_i = '0;
    logic bus_grant_i = 1'b0, bus_rel_i = 1'b0, bus_ready_i = 1'b0;
    logic req_ack, rsp_valid, bus_req_o, chain_gnt_o, bus_drive_o;
    logic as_o, das_o, rd_o, dalo_o, dali_o;
    logic [1:0] bm_o;
    logic [15:0] rsp_rdata, dal_out_o;
    logic [7:0] addr_hi_o;

    int n_chk = 0, n_bad = 0;
    logic gnt_en = 1'b0, grant_man = 1'b0;
    int wait_k = 0;

    // monitor state
    int cyc_cnt = 0, rsp_cnt = 0, sess_cnt = 0, r9_bad = 0, sc = 0;
    logic drive_q = 1'b0, das_q = 1'b0;
    logic s_as_a, s_dalo_a, s_dali_a, s_rd_a, s_as_d, s_dalo_d, s_dali_d;
    logic [15:0] s_dal_a, s_dal_d, s_rdata;
    logic [7:0] s_hi_a;
    logic [1:0] s_bm_a;

    dmab_top dut_i (
        .clk(clk), .rst(rst), .cfg_alt_mode(cfg_alt_mode), .cfg_as_low(cfg_as_low),
        .cfg_burst(cfg_burst), .cfg_rel_en(cfg_rel_en), .req_valid(req_valid),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_byte(req_byte), .req_ack(req_ack), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .bus_req_o(bus_req_o), .bus_grant_i(bus_grant_i),
        .bus_rel_i(bus_rel_i), .bus_ready_i(bus_ready_i), .chain_gnt_o(chain_gnt_o),
        .bus_drive_o(bus_drive_o), .addr_hi_o(addr_hi_o), .dal_out_o(dal_out_o),
        .dal_in_i(dal_in_i), .as_o(as_o), .das_o(das_o), .rd_o(rd_o),
        .dalo_o(dalo_o), .dali_o(dali_o), .bm_o(bm_o)
    );

    always #10 clk = ~clk;

    // bus partner: grant follows request, ready after the wanted wait, snapshots
    always @(negedge clk) begin
        int nsc;
        bus_grant_i <= gnt_en ? bus_req_o : grant_man;
        nsc = das_o ? sc + 1 : 0;
        sc <= nsc;
        bus_ready_i <= das_o && (nsc >= 3 + wait_k);
        if (bus_drive_o) cyc_cnt <= cyc_cnt + 1;
        if (rsp_valid) begin
            rsp_cnt <= rsp_cnt + 1;
            s_rdata <= rsp_rdata;
        end
        if (bus_drive_o && !drive_q) begin
            sess_cnt <= sess_cnt + 1;
            s_as_a <= as_o; s_dal_a <= dal_out_o; s_hi_a <= addr_hi_o;
            s_dalo_a <= dalo_o; s_dali_a <= dali_o; s_rd_a <= rd_o; s_bm_a <= bm_o;
        end
        if (das_o && !das_q) begin
            s_as_d <= as_o; s_dal_d <= dal_out_o; s_dalo_d <= dalo_o; s_dali_d <= dali_o;
        end
        if (drive_q && !bus_drive_o && bus_req_o) r9_bad <= r9_bad + 1;
        drive_q <= bus_drive_o;
        das_q   <= das_o;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // present n requests; pulse release after the rel_at-th acceptance
    task automatic feed(input int n, input int rel_at);
        int issued = 0;
        req_valid = 1'b1;
        while (issued < n) begin
            @(negedge clk);
            bus_rel_i = 1'b0;
            #5;
            if (req_ack) begin
                issued++;
                req_wdata = 16'(issued);
                if (issued == rel_at) begin
                    @(negedge clk);
                    bus_rel_i = 1'b1;
                end
            end
        end
        @(negedge clk);
        bus_rel_i = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int b_cyc, b_rsp;
        cfg_alt_mode = v.alt; cfg_as_low = v.asl; cfg_burst = 2'b00;
        req_addr = v.addr; req_wdata = v.wd; req_write = v.wr; req_byte = v.byt;
        wait_k = int'(v.k); dal_in_i = v.rdv; gnt_en = 1'b1;
        @(negedge clk);
        b_cyc = cyc_cnt; b_rsp = rsp_cnt;
        req_valid = 1'b1;
        do begin @(negedge clk); #5; end while (!req_ack);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        #5;
        chk($sformatf("R1 vec%0d cycle length", idx), cyc_cnt - b_cyc, 6 + int'(v.k));
        chk($sformatf("R1 vec%0d one result", idx), rsp_cnt - b_rsp, 1);
        if (v.alt) chk($sformatf("R3 vec%0d lanes", idx), s_bm_a, v.ebm);
        else       chk($sformatf("R2 vec%0d lanes", idx), s_bm_a, v.ebm);
        chk($sformatf("R7 vec%0d addr low", idx), s_dal_a, v.edal);
        chk($sformatf("R7 vec%0d addr high", idx), s_hi_a, v.addr[23:16]);
        chk($sformatf("R4 vec%0d strobe addr phase", idx), s_as_a, !v.asl);
        chk($sformatf("R4 vec%0d strobe data phase", idx), s_as_d, v.asl);
        chk($sformatf("R5 vec%0d direction", idx), s_rd_a, !v.wr);
        chk($sformatf("R6 vec%0d enables addr", idx), {s_dalo_a, s_dali_a}, 2'b10);
        chk($sformatf("R6 vec%0d enables data", idx), {s_dalo_d, s_dali_d}, {v.wr, !v.wr});
        if (v.wr) chk($sformatf("R7 vec%0d write data", idx), s_dal_d, v.wd);
        else      chk($sformatf("R7 vec%0d read data", idx), s_rdata, v.rdv);
    endtask

    task automatic burst_run(input logic [1:0] sel, input logic rel_en, input int n,
                             input int rel_at, input int exp_sess, input string tag);
        int b_s, b_r;
        cfg_alt_mode = 1'b0; cfg_burst = sel; cfg_rel_en = rel_en;
        req_write = 1'b1; req_byte = 1'b0; req_addr = 24'h000100;
        wait_k = 0; gnt_en = 1'b1;
        @(negedge clk);
        b_s = sess_cnt; b_r = rsp_cnt;
        feed(n, rel_at);
        repeat (30) @(negedge clk);
        #5;
        chk({tag, " sessions"}, sess_cnt - b_s, exp_sess);
        chk({tag, " transfers"}, rsp_cnt - b_r, n);
    endtask

    task automatic style_test(input logic alt);
        do_reset();
        cfg_alt_mode = alt; gnt_en = 1'b0; grant_man = 1'b1; wait_k = 0;
        req_write = 1'b0; req_byte = 1'b0; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        #5;
        chk("R8 no request while granted", bus_req_o, 0);
        chk("R10 chain passes grant when idle", chain_gnt_o, alt);
        grant_man = 1'b0;
        @(negedge clk);
        @(negedge clk); #5;
        chk("R8 request one clock after grant low", bus_req_o, !alt);
        @(negedge clk); #5;
        chk("R8 request by second clock", bus_req_o, 1);
        chk("R13 no drive before grant", {bus_drive_o, das_o, dalo_o, dali_o, as_o}, 0);
        chk("R13 no drive data before grant", dal_out_o, 0);
        grant_man = 1'b1;
        @(negedge clk); @(negedge clk); #5;
        chk("R10 chain held while requesting", chain_gnt_o, 0);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #5;
        chk("R13 reset drive off", {bus_drive_o, bus_req_o, rsp_valid, req_ack, chain_gnt_o}, 0);
        chk("R13 reset bus lines", {dal_out_o, addr_hi_o, bm_o}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
        chk("R9 request drops with last cycle", r9_bad, 0);

        style_test(1'b0);
        style_test(1'b1);
        cfg_alt_mode = 1'b0;
        grant_man = 1'b1; gnt_en = 1'b0;
        repeat (2) @(negedge clk); #5;
        chk("R10 no chain in style 0", chain_gnt_o, 0);
        grant_man = 1'b0;
        do_reset();

        burst_run(2'b00, 1'b0, 5, 0, 5, "R11 burst of one");
        burst_run(2'b01, 1'b0, 16, 0, 2, "R11 burst of eight");
        burst_run(2'b10, 1'b0, 10, 0, 1, "R11 unlimited burst");
        burst_run(2'b10, 1'b1, 10, 3, 2, "R12 release ends burst");
        burst_run(2'b10, 1'b0, 10, 3, 1, "R12 release ignored when disabled");
        chk("R9 request drops with last cycle after bursts", r9_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule